// File: doc/BRIEF.md
# DMA Word Transfer Sequencer

This block runs a CPU-started transfer of 16-bit words. The CPU programs a word-addressed start location and a word count through a small register port. It then writes a 2-bit mode value to start the sequence. The block clears the mode field by itself when the sequence is over.

There are two modes. In linear mode the block issues one bus request per word. The first request goes to the programmed start address, and the address steps by one word for each accepted beat. In image mode the start address is not used. Incoming words pass straight to an image-entry sink. The end of the transfer then depends on how the word count compares with the image pixel total, which is X size times Y size:

- If the pixel total is smaller than the word count, image mode ends early and the surplus words are swallowed.
- If the pixel total is larger than the word count, the block keeps waiting until the full pixel total has arrived.

Top module: `dma_word_seq`

## Requirements
- R1: After reset, all four registers read 0, and `busy_o`, `bus_req_o`, `img_we_o` and `in_ready_o` are low.
- R2: Register 1 holds start-address bits A22..A16 in data bits 6..0. Register 2 holds A15..A1 in data bits 15..1. Reserved bits (15..7 of register 1, bit 0 of register 2) read 0.
- R3: Register 3 holds the word count in bits 13..0. Bits 15..14 read 0.
- R4: Writing register 0 while idle, with data bit 1 set, starts a transfer. Data bit 0 selects the mode: 0 is linear (mode 2'b10), 1 is image (mode 2'b11). From the next cycle, `busy_o` is high and register 0 reads the mode. A write with bit 1 clear starts nothing.
- R5: In linear mode, the first `bus_addr_o` is {A22..A16, A15..A1}. It advances by one after each cycle with `bus_req_o` and `bus_ready_i` both high, and it holds while `bus_ready_i` is low.
- R6: Linear mode makes exactly count accepted beats. The mode field reads 0 and `busy_o` is low in the cycle after the last accepted beat.
- R7: A word count of 0 clears the mode on the clock after the start, in either mode. It raises no bus request and forwards no word.
- R8: In image mode, `bus_req_o` stays low. Each accepted input word appears on `img_data_o` with `img_we_o` high in the same cycle.
- R9: In image mode, when the pixel total is below the count, the mode ends after pixel-total words have been forwarded. The next (count − pixel total) words are accepted (`in_ready_o` high) but not forwarded. After that, `in_ready_o` is low.
- R10: In image mode, when the pixel total exceeds the count, `busy_o` stays high after count words and the mode ends once pixel-total words have been forwarded.
- R11: While `busy_o` is high, writes to any register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_we_i | input | 1 | Register write strobe |
| cpu_addr_i | input | 2 | Register select: 0 mode, 1 address high, 2 address low, 3 count |
| cpu_wdata_i | input | 16 | Register write data |
| cpu_rdata_o | output | 16 | Register read data (combinational) |
| img_x_i | input | 10 | Image X size |
| img_y_i | input | 10 | Image Y size |
| busy_o | output | 1 | Transfer sequence in progress |
| bus_req_o | output | 1 | Linear bus request valid |
| bus_addr_o | output | 22 | Word address of the current request |
| bus_ready_i | input | 1 | Bus accepts the request |
| in_valid_i | input | 1 | Incoming image word valid |
| in_data_i | input | 16 | Incoming image word |
| in_ready_o | output | 1 | Incoming word accepted |
| img_we_o | output | 1 | Image sink write strobe |
| img_data_o | output | 16 | Image sink data |

## Verification
In image mode with a short pixel total, two events can fall on the same clock edge. The last forwarded word and the end of image mode coincide, so the very next incoming word must already take the discard path. The bench provokes this by holding `in_valid_i` high without gaps across that boundary. It then judges the result by counting forwarded words against swallowed words, and by checking that `in_ready_o` drops once the surplus has been consumed.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_HI_W = 7;
  localparam int ADDR_LO_W = 15;
  localparam int ADDR_W    = ADDR_HI_W + ADDR_LO_W;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_LIN  = 2'b10,
    MODE_IMG  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_AHI   = 2'd1,
    REG_ALO   = 2'd2,
    REG_COUNT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [1:0]          sel_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                busy_i,
  output logic [ADDR_W-1:0]   start_addr_o,
  output logic [CNT_W-1:0]    count_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [ADDR_HI_W-1:0] hi_q;
  logic [ADDR_LO_W-1:0] lo_q;
  logic [CNT_W-1:0]     cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      cnt_q <= '0;
    end else if (we_i && !busy_i) begin
      case (sel_i)
        REG_AHI:   hi_q  <= wdata_i[ADDR_HI_W-1:0];
        REG_ALO:   lo_q  <= wdata_i[ADDR_LO_W:1];
        REG_COUNT: cnt_q <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign start_addr_o = {hi_q, lo_q};
  assign count_o      = cnt_q;

  always_comb begin
    case (sel_i)
      REG_AHI:   rdata_o = DATA_W'(hi_q);
      REG_ALO:   rdata_o = DATA_W'({lo_q, 1'b0});
      REG_COUNT: rdata_o = DATA_W'(cnt_q);
      default:   rdata_o = '0;
    endcase
  end

  a_r11_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($stable(hi_q) && $stable(lo_q) && $stable(cnt_q)));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int TOT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              img_sel_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [TOT_W-1:0]  pix_total_i,
  output logic [1:0]        mode_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_ready_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              img_we_o
);
  localparam int REM_W = (TOT_W > CNT_W) ? TOT_W : CNT_W;

  mode_e            mode_q;
  logic [REM_W-1:0] rem_q, drain_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REM_W-1:0] cnt_ext, tot_ext;
  logic             lin_act, img_act, drain_act;

  assign cnt_ext = REM_W'(count_i);
  assign tot_ext = REM_W'(pix_total_i);

  assign lin_act   = (mode_q == MODE_LIN) && (rem_q != '0);
  assign img_act   = (mode_q == MODE_IMG) && (rem_q != '0);
  assign drain_act = (mode_q == MODE_IDLE) && (drain_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_IDLE;
      rem_q   <= '0;
      drain_q <= '0;
      addr_q  <= '0;
    end else if (start_i) begin
      mode_q  <= img_sel_i ? MODE_IMG : MODE_LIN;
      addr_q  <= start_addr_i;
      if (!img_sel_i)            rem_q <= cnt_ext;
      else if (cnt_ext == '0)    rem_q <= '0;
      else                       rem_q <= tot_ext;
      // surplus words to swallow once a short image ends
      drain_q <= (img_sel_i && cnt_ext > tot_ext) ? cnt_ext - tot_ext : '0;
    end else if (mode_q != MODE_IDLE) begin
      if (rem_q == '0) begin
        mode_q <= MODE_IDLE;
      end else if ((lin_act && bus_ready_i) || (img_act && in_valid_i)) begin
        rem_q <= rem_q - 1'b1;
        if (lin_act) addr_q <= addr_q + 1'b1;
        if (rem_q == REM_W'(1)) mode_q <= MODE_IDLE;
      end
    end else if (drain_act && in_valid_i) begin
      drain_q <= drain_q - 1'b1;
    end
  end

  assign mode_o     = mode_q;
  assign bus_req_o  = lin_act;
  assign bus_addr_o = addr_q;
  assign in_ready_o = img_act || drain_act;
  assign img_we_o   = img_act && in_valid_i;

  a_r4_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> mode_o[1]);
  a_r5_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ready_i) |=> (!bus_req_o || bus_addr_o == $past(bus_addr_o) + 1'b1));
  a_r5_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i && !start_i) |=> (bus_req_o && $stable(bus_addr_o)));
  a_r7_zero_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o[1] && rem_q == '0 && !start_i) |=> (mode_o == MODE_IDLE));
  a_r8_img_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_IMG) |-> !bus_req_o);
  a_r9_idle_no_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o[1] |-> !img_we_o);
endmodule

// File: rtl/dma_word_seq.sv
module dma_word_seq
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int DIM_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cpu_we_i,
  input  logic [1:0]          cpu_addr_i,
  input  logic [DATA_W-1:0]   cpu_wdata_i,
  output logic [DATA_W-1:0]   cpu_rdata_o,
  input  logic [DIM_W-1:0]    img_x_i,
  input  logic [DIM_W-1:0]    img_y_i,
  output logic                busy_o,
  output logic                bus_req_o,
  output logic [ADDR_W-1:0]   bus_addr_o,
  input  logic                bus_ready_i,
  input  logic                in_valid_i,
  input  logic [DATA_W-1:0]   in_data_i,
  output logic                in_ready_o,
  output logic                img_we_o,
  output logic [DATA_W-1:0]   img_data_o
);
  localparam int TOT_W = 2 * DIM_W;

  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  count;
  logic [TOT_W-1:0]  pix_total;
  logic [DATA_W-1:0] reg_rdata;
  logic [1:0]        mode;
  logic              start;

  assign pix_total = TOT_W'(img_x_i) * TOT_W'(img_y_i);
  assign busy_o    = mode[1];
  assign start     = cpu_we_i && (cpu_addr_i == REG_MODE) && cpu_wdata_i[1] && !busy_o;

  dma_seq_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cpu_we_i),
    .sel_i        (cpu_addr_i),
    .wdata_i      (cpu_wdata_i),
    .busy_i       (busy_o),
    .start_addr_o (start_addr),
    .count_o      (count),
    .rdata_o      (reg_rdata)
  );

  dma_seq_ctrl #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .img_sel_i    (cpu_wdata_i[0]),
    .start_addr_i (start_addr),
    .count_i      (count),
    .pix_total_i  (pix_total),
    .mode_o       (mode),
    .bus_req_o    (bus_req_o),
    .bus_addr_o   (bus_addr_o),
    .bus_ready_i  (bus_ready_i),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .img_we_o     (img_we_o)
  );

  assign img_data_o  = in_data_i;
  assign cpu_rdata_o = (cpu_addr_i == REG_MODE) ? DATA_W'(mode) : reg_rdata;

  a_r8_fwd_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    img_we_o |-> (in_valid_i && in_ready_o && img_data_o == in_data_i));
endmodule

// File: tb/dma_word_seq_bench.sv
module dma_word_seq_bench;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic        we = 0;
  logic [1:0]  sel = 0;
  logic [15:0] wd = 0, rd;
  logic [9:0]  ix = 0, iy = 0;
  logic        busy, req, rdy = 0, iv = 0, irdy, iwe;
  logic [21:0] addr;
  logic [15:0] idat = 0, odat;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_word_seq u_dma_word_seq (
    .clk_i(clk), .rst_ni(rst_n), .cpu_we_i(we), .cpu_addr_i(sel), .cpu_wdata_i(wd),
    .cpu_rdata_o(rd), .img_x_i(ix), .img_y_i(iy), .busy_o(busy), .bus_req_o(req),
    .bus_addr_o(addr), .bus_ready_i(rdy), .in_valid_i(iv), .in_data_i(idat),
    .in_ready_o(irdy), .img_we_o(iwe), .img_data_o(odat)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); we = 1; sel = s; wd = d;
    @(negedge clk); we = 0; #1;
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [15:0] exp, input string tag);
    @(negedge clk); sel = s; #1;
    chk(rd == exp, tag, rd, exp);
  endtask

  task automatic t_reset;
    for (int r = 0; r < 4; r++) rd_chk(r[1:0], 16'h0, "R1 reg reset");
    chk(!busy && !req && !iwe && !irdy, "R1 outputs idle", {busy, req, iwe, irdy}, 0);
  endtask

  task automatic t_layout;
    wr(2'd1, 16'hFFFF); rd_chk(2'd1, 16'h007F, "R2 high reg");
    wr(2'd2, 16'hFFFF); rd_chk(2'd2, 16'hFFFE, "R2 low reg");
    wr(2'd3, 16'hFFFF); rd_chk(2'd3, 16'h3FFF, "R3 count reg");
    wr(2'd0, 16'h0001); chk(!busy, "R4 no start without bit1", busy, 0);
  endtask

  task automatic t_linear;
    int beats = 0, cyc = 0;
    logic [21:0] exp_a = 22'h091A2B;
    wr(2'd1, 16'h0012); wr(2'd2, 16'h3456); wr(2'd3, 16'd5);
    wr(2'd0, 16'h0002);
    chk(busy, "R4 busy after start", busy, 1);
    sel = 2'd0; #1; chk(rd == 16'h2, "R4 mode reads 10", rd, 2);
    while (busy && cyc < 50) begin
      rdy = (cyc % 3) != 1; #1;
      if (req) begin
        chk(addr == exp_a, "R5 bus address", addr, exp_a);
        if (rdy) begin beats++; exp_a++; end
      end
      @(negedge clk); cyc++;
    end
    rdy = 0; #1;
    chk(beats == 5, "R6 beat count", beats, 5);
    chk(!busy && !req, "R6 ended", busy, 0);
    sel = 2'd0; #1; chk(rd == 0, "R6 mode cleared", rd, 0);
  endtask

  task automatic t_busy_writes;
    int beats = 0;
    wr(2'd1, 16'h0000); wr(2'd2, 16'h0010); wr(2'd3, 16'd4);
    wr(2'd0, 16'h0002);
    wr(2'd3, 16'd9); wr(2'd2, 16'h0100); wr(2'd0, 16'h0003);
    chk(req && addr == 22'h8, "R11 addr unchanged", addr, 22'h8);
    rd_chk(2'd3, 16'd4, "R11 count unchanged");
    rd_chk(2'd2, 16'h0010, "R11 addr low unchanged");
    rd_chk(2'd0, 16'h2, "R11 mode unchanged");
    rdy = 1;
    for (int c = 0; c < 10 && busy; c++) begin
      #1; if (req) beats++;
      @(negedge clk);
    end
    rdy = 0; #1;
    chk(beats == 4 && !busy, "R11 run uses original count", beats, 4);
  endtask

  task automatic t_zero(input bit img);
    bit seen = 0;
    wr(2'd3, 16'd0);
    iv = 1; rdy = 1;
    wr(2'd0, img ? 16'h3 : 16'h2);
    chk(busy, "R7 busy one cycle", busy, 1);
    seen = req || iwe;
    @(negedge clk); #1;
    chk(!busy, "R7 zero count clears", busy, 0);
    chk(!seen && !req && !iwe, "R7 no activity", seen, 0);
    iv = 0; rdy = 0;
  endtask

  task automatic t_img_short;
    int fwd = 0, drop = 0;
    ix = 3; iy = 1;
    wr(2'd1, 16'h007F); wr(2'd3, 16'd5);
    wr(2'd0, 16'h0003);
    for (int c = 0; c < 8; c++) begin
      iv = 1; idat = 16'hA000 + 16'(fwd + drop); #1;
      chk(!req, "R8 no bus in image", req, 0);
      if (irdy) begin
        if (iwe) begin
          chk(odat == idat, "R8 forwarded data", odat, idat);
          fwd++;
        end else drop++;
      end
      @(negedge clk);
    end
    #1;
    chk(fwd == 3, "R9 forwarded total", fwd, 3);
    chk(drop == 2, "R9 surplus dropped", drop, 2);
    chk(!irdy && !busy, "R9 ready low after drain", irdy, 0);
    iv = 0;
  endtask

  task automatic t_img_long;
    int fwd = 0;
    bit early = 0;
    ix = 2; iy = 3;
    wr(2'd3, 16'd4);
    wr(2'd0, 16'h0003);
    for (int c = 0; c < 30 && fwd < 6; c++) begin
      iv = c[0]; idat = 16'h5000 + 16'(fwd); #1;
      if (fwd >= 4 && !busy) early = 1;
      if (iwe) fwd++;
      @(negedge clk);
    end
    iv = 0; #1;
    chk(!early, "R10 stays busy past count", early, 0);
    chk(fwd == 6, "R10 all pixels forwarded", fwd, 6);
    chk(!busy, "R10 ends at pixel total", busy, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1;
    t_reset();
    t_layout();
    t_linear();
    t_busy_writes();
    t_zero(0);
    t_zero(1);
    t_img_short();
    t_img_long();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule